// File: doc/BRIEF.md
# Interleaved Triangular-Current-Mode Gate Sequencer

This block produces the gate timing for a two-leg, interleaved, triangular-current-mode totem-pole boost stage. A rising edge on the master leg's zero-crossing-detect input starts each master switching cycle. Within that cycle the block places four gate edges at offsets built from five duration inputs, all counted in clock ticks:

- the extra rectifier conduction time;
- the reverse resonance time;
- the reverse and forward main-switch conduction times, which are always added together;
- the forward resonance time.

The block counts the ticks between successive master starts. Half of the period just completed starts a replica of the same edge pattern on the slave leg. This keeps the two legs half a switching period apart while the period changes from cycle to cycle.

A line-polarity flag selects which of the two switches in each leg acts as the main switch and which acts as the synchronous rectifier. The durations and the flag are captured only at a cycle start, so a pattern already running is never altered. A missing zero-crossing event forces every gate low and raises a fault flag.

Top module: `tcm_ilv_seq`

## Requirements
- R1: A master cycle starts on the first clock edge at which `zcd_i` is seen high after having been low. Offset t of a cycle means the state after the t-th edge following that start edge. While `zcd_i` stays high, no further cycle starts.
- R2: The rectifier gate of a leg is high from offset 0 to offset `t_ext` minus one. It is low from offset `t_ext` onwards, until the main switch has turned off again.
- R3: The main gate of a leg is high for offsets in [E_on, E_off), where E_on = `t_ext`+`t_rres` and E_off = E_on+`t_ron`+`t_fon`. It is low at all other offsets.
- R4: The rectifier gate goes high again at offset E_off+`t_fres`. It stays high until that leg's next cycle start, and then on until the `t_ext` offset of the new cycle.
- R5: With `t_ext` = 0, the rectifier gate is already low at offset 0, and no extra rectifier conduction occurs.
- R6: With polarity flag 1, the main switch is the low-side gate (`*_lo_o`) and the rectifier is the high-side gate (`*_hi_o`). With flag 0 the two roles are swapped. The flag is captured at the cycle start, and changing it mid-cycle has no effect on the running pattern.
- R7: The five durations are captured at the master cycle start. A change of them mid-cycle does not alter the running pattern of either leg.
- R8: Let P be the tick count from the previous master start to the current one. The slave leg starts max(floor(P/2),1) ticks after the current master start. No slave start follows the first master cycle after reset or after a fault. A slave start that is still pending is cancelled by the next master start.
- R9: The slave leg runs the R2 to R4 pattern with the durations and polarity captured by the master cycle it follows.
- R10: The main and rectifier gates of one leg are never high at the same time. If both are requested, the rectifier is held off.
- R11: If no new master start comes within `TMO_TICKS` ticks of the last one, then at offset `TMO_TICKS` every gate goes low and `fault_o` goes high. The next master start clears `fault_o`.
- R12: While `rst_ni` is low, and after reset until the first master start, all gates and `fault_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Tick clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| zcd_i | input | 1 | Master zero-crossing-detect event |
| pol_i | input | 1 | Line polarity: 1 = main on low side |
| t_ext_i | input | DUR_W | Extra rectifier conduction time |
| t_rres_i | input | DUR_W | Reverse resonance time |
| t_ron_i | input | DUR_W | Reverse main-switch conduction time |
| t_fon_i | input | DUR_W | Forward main-switch conduction time |
| t_fres_i | input | DUR_W | Forward resonance time |
| m_hi_o | output | 1 | Master leg high-side gate |
| m_lo_o | output | 1 | Master leg low-side gate |
| s_hi_o | output | 1 | Slave leg high-side gate |
| s_lo_o | output | 1 | Slave leg low-side gate |
| fault_o | output | 1 | Missing zero-crossing fault |

## Verification
The edge pattern is exercised with these inputs:
- generic duration sets under both polarities, which separates the main role from the rectifier role and the two switches of each leg;
- a zero extra-conduction time and an all-zero set, which expose off-by-one errors at the first offset;
- a period shorter than the pattern, which shows whether a restart cuts a running pattern;
- a held-high detect input, which distinguishes edge detection from level detection;
- a mid-cycle change of durations and flag, which shows whether the values are captured at the start.

Odd and tiny periods test the halving and the minimum delay of one tick, and a pending slave start overtaken by a new master start shows whether it is cancelled. A timeout run followed by restarts shows that the fault clears, and that no slave start follows the first cycle after the fault.

// File: rtl/tcm_seq_pkg.sv
package tcm_seq_pkg;
  parameter int unsigned DUR_W = 10;

  typedef enum logic {
    POL_NEG = 1'b0,
    POL_POS = 1'b1
  } tcm_pol_e;

  typedef struct packed {
    logic [DUR_W-1:0] ext;
    logic [DUR_W-1:0] rres;
    logic [DUR_W-1:0] ron;
    logic [DUR_W-1:0] fon;
    logic [DUR_W-1:0] fres;
  } tcm_dur_t;
endpackage

// File: rtl/tcm_zcd_edge.sv
module tcm_zcd_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic zcd_i,
  output logic rise_o
);
  logic zcd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) zcd_q <= 1'b0;
    else         zcd_q <= zcd_i;
  end

  assign rise_o = zcd_i & ~zcd_q;
endmodule

// File: rtl/tcm_edge_calc.sv
module tcm_edge_calc
  import tcm_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  tcm_dur_t         dur_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             rect_o,
  output logic             main_o
);
  localparam int unsigned PAD_W = CNT_W - DUR_W;

  logic [CNT_W-1:0] rect_off, main_on, main_off, rect_on;
  logic             rect_req, main_req;

  function automatic logic [CNT_W-1:0] zext(input logic [DUR_W-1:0] v);
    return {{PAD_W{1'b0}}, v};
  endfunction

  // cumulative offsets; CNT_W >= DUR_W+3 keeps the five-term sum from wrapping
  assign rect_off = zext(dur_i.ext);
  assign main_on  = rect_off + zext(dur_i.rres);
  assign main_off = main_on + zext(dur_i.ron) + zext(dur_i.fon);
  assign rect_on  = main_off + zext(dur_i.fres);

  assign rect_req = (cnt_i < rect_off) || (cnt_i >= rect_on);
  assign main_req = (cnt_i >= main_on) && (cnt_i < main_off);

  // interlock: rectifier yields to main
  assign main_o = main_req;
  assign rect_o = rect_req & ~main_req;
endmodule

// File: rtl/tcm_leg.sv
module tcm_leg
  import tcm_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             kill_i,
  input  tcm_dur_t         dur_i,
  input  tcm_pol_e         pol_i,
  output logic             act_o,
  output logic [CNT_W-1:0] cnt_o,
  output tcm_dur_t         dur_o,
  output tcm_pol_e         pol_o,
  output logic             hi_o,
  output logic             lo_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             act_q;
  logic [CNT_W-1:0] cnt_q;
  tcm_dur_t         dur_q;
  tcm_pol_e         pol_q;
  logic             rect_g, main_g;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      dur_q <= '0;
      pol_q <= POL_NEG;
    end else if (kill_i) begin
      act_q <= 1'b0;
    end else if (start_i) begin
      act_q <= 1'b1;
      cnt_q <= '0;
      dur_q <= dur_i;
      pol_q <= pol_i;
    end else if (act_q && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  tcm_edge_calc #(.CNT_W(CNT_W)) u_calc (
    .dur_i  (dur_q),
    .cnt_i  (cnt_q),
    .rect_o (rect_g),
    .main_o (main_g)
  );

  always_comb begin
    hi_o = 1'b0;
    lo_o = 1'b0;
    if (act_q) begin
      if (pol_q == POL_POS) begin
        hi_o = rect_g;
        lo_o = main_g;
      end else begin
        hi_o = main_g;
        lo_o = rect_g;
      end
    end
  end

  assign act_o = act_q;
  assign cnt_o = cnt_q;
  assign dur_o = dur_q;
  assign pol_o = pol_q;
endmodule

// File: rtl/tcm_half_dly.sv
module tcm_half_dly #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mstart_i,
  input  logic             kill_i,
  input  logic             mact_i,
  input  logic [CNT_W-1:0] mcnt_i,
  output logic             sstart_o
);
  logic             pend_q;
  logic [CNT_W-1:0] tgt_q;
  logic [CNT_W-1:0] per, half, tgt_d;

  // period just ended: master counter value at the restart edge plus one
  assign per   = mcnt_i + 1'b1;
  assign half  = per >> 1;
  assign tgt_d = (half == '0) ? CNT_W'(1) : half;

  assign sstart_o = pend_q & ~mstart_i & ~kill_i & (mcnt_i == (tgt_q - 1'b1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      tgt_q  <= CNT_W'(1);
    end else if (kill_i) begin
      pend_q <= 1'b0;
    end else if (mstart_i) begin
      pend_q <= mact_i;
      tgt_q  <= tgt_d;
    end else if (sstart_o) begin
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tcm_ilv_seq.sv
module tcm_ilv_seq
  import tcm_seq_pkg::*;
#(
  parameter int unsigned TMO_TICKS = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             zcd_i,
  input  logic             pol_i,
  input  logic [DUR_W-1:0] t_ext_i,
  input  logic [DUR_W-1:0] t_rres_i,
  input  logic [DUR_W-1:0] t_ron_i,
  input  logic [DUR_W-1:0] t_fon_i,
  input  logic [DUR_W-1:0] t_fres_i,
  output logic             m_hi_o,
  output logic             m_lo_o,
  output logic             s_hi_o,
  output logic             s_lo_o,
  output logic             fault_o
);
  localparam int unsigned N_LEG = 2;
  localparam int unsigned TMO_W = $clog2(2 * TMO_TICKS + 2) + 1;
  localparam int unsigned CNT_W = (TMO_W > DUR_W + 3) ? TMO_W : DUR_W + 3;
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TMO_TICKS - 1);

  logic             zcd_rise, s_start, tmo_hit, fault_q;
  logic             leg_start [N_LEG];
  tcm_dur_t         leg_dur_in[N_LEG];
  tcm_pol_e         leg_pol_in[N_LEG];
  logic             leg_act   [N_LEG];
  logic [CNT_W-1:0] leg_cnt   [N_LEG];
  tcm_dur_t         leg_dur_sh[N_LEG];
  tcm_pol_e         leg_pol_sh[N_LEG];
  logic             leg_hi    [N_LEG];
  logic             leg_lo    [N_LEG];

  tcm_zcd_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .zcd_i  (zcd_i),
    .rise_o (zcd_rise)
  );

  assign tmo_hit = leg_act[0] & (leg_cnt[0] == TMO_LAST) & ~zcd_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       fault_q <= 1'b0;
    else if (tmo_hit)  fault_q <= 1'b1;
    else if (zcd_rise) fault_q <= 1'b0;
  end

  // leg 0 = master, fed from ports; leg 1 = slave, copies master shadow
  assign leg_start[0]  = zcd_rise;
  assign leg_dur_in[0] = '{ext: t_ext_i, rres: t_rres_i, ron: t_ron_i,
                           fon: t_fon_i, fres: t_fres_i};
  assign leg_pol_in[0] = tcm_pol_e'(pol_i);
  assign leg_start[1]  = s_start;
  assign leg_dur_in[1] = leg_dur_sh[0];
  assign leg_pol_in[1] = leg_pol_sh[0];

  for (genvar g = 0; g < N_LEG; g++) begin : g_leg
    tcm_leg #(.CNT_W(CNT_W)) u_leg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (leg_start[g]),
      .kill_i  (tmo_hit),
      .dur_i   (leg_dur_in[g]),
      .pol_i   (leg_pol_in[g]),
      .act_o   (leg_act[g]),
      .cnt_o   (leg_cnt[g]),
      .dur_o   (leg_dur_sh[g]),
      .pol_o   (leg_pol_sh[g]),
      .hi_o    (leg_hi[g]),
      .lo_o    (leg_lo[g])
    );
  end

  tcm_half_dly #(.CNT_W(CNT_W)) u_half (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mstart_i (zcd_rise),
    .kill_i   (tmo_hit),
    .mact_i   (leg_act[0]),
    .mcnt_i   (leg_cnt[0]),
    .sstart_o (s_start)
  );

  assign m_hi_o  = leg_hi[0];
  assign m_lo_o  = leg_lo[0];
  assign s_hi_o  = leg_hi[1];
  assign s_lo_o  = leg_lo[1];
  assign fault_o = fault_q;
endmodule

// File: rtl/tcm_ilv_seq_chk.sv
module tcm_ilv_seq_chk #(
  parameter int unsigned TMO_TICKS = 1000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic zcd_i,
  input logic m_hi_o,
  input logic m_lo_o,
  input logic s_hi_o,
  input logic s_lo_o,
  input logic fault_o
);
  localparam int unsigned TW = $clog2(TMO_TICKS + 2);
  localparam logic [TW-1:0] TMO = TW'(TMO_TICKS);

  logic          zcd_p, seen_q;
  logic [TW-1:0] since_q;

  // independent tick count since the last rising detect edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zcd_p   <= 1'b0;
      seen_q  <= 1'b0;
      since_q <= '0;
    end else begin
      zcd_p <= zcd_i;
      if (zcd_i && !zcd_p) begin
        seen_q  <= 1'b1;
        since_q <= '0;
      end else if (seen_q && since_q != TMO) begin
        since_q <= since_q + 1'b1;
      end
    end
  end

  AST_MASTER_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(m_hi_o && m_lo_o)); // R10
  AST_SLAVE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(s_hi_o && s_lo_o)); // R10
  AST_FAULT_GATES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !(m_hi_o || m_lo_o || s_hi_o || s_lo_o)); // R11
  AST_FAULT_ON_TMO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && since_q == TMO) |-> fault_o); // R11
  AST_FAULT_ONLY_TMO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (seen_q && since_q == TMO)); // R11
  AST_FAULT_CLR_ON_ZCD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_o) |-> $past(zcd_i)); // R11
endmodule

bind tcm_ilv_seq tcm_ilv_seq_chk #(.TMO_TICKS(TMO_TICKS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .zcd_i   (zcd_i),
  .m_hi_o  (m_hi_o),
  .m_lo_o  (m_lo_o),
  .s_hi_o  (s_hi_o),
  .s_lo_o  (s_lo_o),
  .fault_o (fault_o)
);

// File: tb/tb_tcm_ilv_seq.sv
module tb_tcm_ilv_seq;
  import tcm_seq_pkg::*;

  localparam int TMO = 1000;
  localparam int NV  = 10;
  // period, ext, rres, ron, fon, fres, pol, hold, scramble
  localparam int VEC[NV][9] = '{
    '{60, 5, 3, 10, 20, 4, 1,  1, 0},
    '{80, 0, 4, 12, 30, 6, 1,  1, 0},
    '{50, 8, 2,  6, 14, 3, 0,  1, 0},
    '{71, 0, 0,  0,  0, 0, 1,  1, 0},
    '{64, 6, 4, 10, 12, 5, 0, 10, 0},
    '{30, 6, 4, 10, 10, 5, 1,  1, 0},
    '{90, 2, 1, 20, 25, 3, 1,  1, 1},
    '{ 3, 0, 1,  1,  0, 0, 1,  1, 0},
    '{50, 3, 2,  5,  5, 2, 0,  1, 0},
    '{45, 4, 3,  7,  9, 2, 1,  1, 0}
  };
  string vtag[NV];

  logic clk = 1'b0, rst_n = 1'b0;
  logic zcd = 1'b0, pol = 1'b0;
  logic [DUR_W-1:0] d_ext = '0, d_rres = '0, d_ron = '0, d_fon = '0, d_fres = '0;
  logic m_hi, m_lo, s_hi, s_lo, fault;

  always #10 clk = ~clk;

  tcm_ilv_seq #(.TMO_TICKS(TMO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .zcd_i(zcd), .pol_i(pol),
    .t_ext_i(d_ext), .t_rres_i(d_rres), .t_ron_i(d_ron), .t_fon_i(d_fon),
    .t_fres_i(d_fres), .m_hi_o(m_hi), .m_lo_o(m_lo), .s_hi_o(s_hi),
    .s_lo_o(s_lo), .fault_o(fault)
  );

  int n_chk = 0, n_err = 0;
  int T = 0;
  bit start_next = 0;
  bit m_act = 0, s_act = 0, p_pend = 0, f_exp = 0;
  int m_start, s_start, p_at, m_pol, s_pol, p_pol, nx_pol;
  int md[5], sd[5], pd[5], nx[5];
  int m_bad, s_bad, ov_bad;
  logic [2:0] m_fa, m_fe;
  logic [1:0] s_fa, s_fe;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] pat(input int t, input int d[5], input int p);
    int e_on, e_off, r_on;
    logic rect, main;
    e_on  = d[0] + d[1];
    e_off = e_on + d[2] + d[3];
    r_on  = e_off + d[4];
    rect  = (t < d[0]) || (t >= r_on);
    main  = (t >= e_on) && (t < e_off);
    if (main) rect = 1'b0;
    return (p != 0) ? {rect, main} : {main, rect};
  endfunction

  task automatic tick();
    logic [2:0] me;
    logic [1:0] se;
    @(posedge clk);
    T++;
    if (start_next) begin
      if (m_act) begin
        int per, h;
        per = T - m_start;
        h = per / 2;
        if (h < 1) h = 1;
        p_pend = 1; p_at = T + h; pd = nx; p_pol = nx_pol;
      end else begin
        p_pend = 0;
      end
      m_act = 1; m_start = T; md = nx; m_pol = nx_pol; f_exp = 0;
    end else if (m_act && (T - m_start) == TMO) begin
      m_act = 0; s_act = 0; p_pend = 0; f_exp = 1;
    end
    if (p_pend && p_at == T) begin
      s_act = 1; s_start = T; sd = pd; s_pol = p_pol; p_pend = 0;
    end
    @(negedge clk);
    me = {m_act ? pat(T - m_start, md, m_pol) : 2'b00, f_exp};
    se = s_act ? pat(T - s_start, sd, s_pol) : 2'b00;
    if ({m_hi, m_lo, fault} !== me) begin
      if (m_bad == 0) begin m_fa = {m_hi, m_lo, fault}; m_fe = me; end
      m_bad++;
    end
    if ({s_hi, s_lo} !== se) begin
      if (s_bad == 0) begin s_fa = {s_hi, s_lo}; s_fe = se; end
      s_bad++;
    end
    if ((m_hi && m_lo) || (s_hi && s_lo)) ov_bad++;
  endtask

  task automatic run_cycle(input int v[9], input string tag);
    m_bad = 0; s_bad = 0;
    d_ext = DUR_W'(v[1]); d_rres = DUR_W'(v[2]); d_ron = DUR_W'(v[3]);
    d_fon = DUR_W'(v[4]); d_fres = DUR_W'(v[5]); pol = v[6][0];
    for (int i = 0; i < 5; i++) nx[i] = v[i+1];
    nx_pol = v[6];
    zcd = 1'b1;
    start_next = 1;
    for (int n = 0; n < v[0]; n++) begin
      tick();
      start_next = 0;
      if (n + 1 == v[7]) zcd = 1'b0;
      if (v[8] != 0 && n == 3) begin
        d_ext = '1; d_rres = 0; d_ron = 1; d_fon = 1; d_fres = '1; pol = ~pol;
      end
    end
    check(m_bad == 0, {tag, " master"}, int'(m_fa), int'(m_fe));
    check(s_bad == 0, {tag, " slave"}, int'(s_fa), int'(s_fe));
  endtask

  initial begin
    vtag[0] = "R2 R3 R4 R6 pol1";
    vtag[1] = "R5 no extra conduction";
    vtag[2] = "R6 pol0 R8 R9";
    vtag[3] = "R5 all zero";
    vtag[4] = "R1 held high";
    vtag[5] = "R4 cut by restart";
    vtag[6] = "R7 mid-cycle change";
    vtag[7] = "R8 pend cancelled";
    vtag[8] = "R8 min delay one";
    vtag[9] = "R9 odd period";

    ov_bad = 0;
    repeat (3) @(negedge clk);
    check({m_hi, m_lo, s_hi, s_lo, fault} == 5'b0, "R12 in reset",
          int'({m_hi, m_lo, s_hi, s_lo, fault}), 0);
    rst_n = 1'b1;
    m_bad = 0; s_bad = 0;
    repeat (5) tick();
    check(m_bad == 0 && s_bad == 0, "R12 idle after reset", m_bad + s_bad, 0);

    for (int k = 0; k < NV; k++) run_cycle(VEC[k], vtag[k]);

    begin
      int vt[9] = '{TMO + 20, 4, 3, 10, 10, 4, 1, 1, 0};
      run_cycle(vt, "R11 timeout");
    end
    check(fault == 1'b1, "R11 fault set", fault, 1);
    check({m_hi, m_lo, s_hi, s_lo} == 4'b0, "R11 gates low",
          int'({m_hi, m_lo, s_hi, s_lo}), 0);
    begin
      int va[9] = '{60, 5, 3, 10, 20, 4, 0, 1, 0};
      int vb[9] = '{60, 4, 2, 12, 18, 3, 1, 1, 0};
      run_cycle(va, "R8 no slave after fault");
      check(fault == 1'b0, "R11 fault cleared", fault, 0);
      check(s_act == 0, "R8 slave idle model", s_act, 0);
      run_cycle(vb, "R9 slave resumes");
    end
    check(ov_bad == 0, "R10 gate exclusion", ov_bad, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule